// File: doc/BRIEF.md
# ECC Error Event Collector

The collector gathers error-correction events from up to sixteen memory channels and presents them to software through a small synchronous register port. Each channel's decoder raises a one-cycle event with a type bit (correctable single-bit or non-correctable), the faulting address and the syndrome. For each channel the block keeps two interrupt enables, two sticky flags, a capture of the address and syndrome of the most recent event, and a saturating count of correctable events.

Enables and flags for all channels are packed four bits per channel into two control words and two status words. Channel 0 takes the most significant nibble of the first word, and the order runs downward from there. Flags are cleared by writing 1. A single interrupt line is raised while any flag has its matching enable set. Reads return data one clock after the address is presented. The reset input is asynchronous and active low, and the block releases it internally on a clock edge.

Top module: `ecc_err_collector`

## Requirements
- R1: Channel n (n<8) uses bits [(7-n)*4+3:(7-n)*4] of control 0 (offset 0x00) and status 0 (0x10). Channel n (n>=8) uses bits [(15-n)*4+3:(15-n)*4] of control 1 (0x04) and status 1 (0x14). Nibble bit 3 is the correctable enable or flag and nibble bit 2 is the non-correctable enable or flag. Nibble bits 1:0 read as 0 and ignore writes.
- R2: A correctable event (valid with type 0) sets the channel's bit-3 flag. A non-correctable event (valid with type 1) sets its bit-2 flag. Flags stay set until they are cleared.
- R3: Writing 1 to a status bit clears that flag. Writing 0 leaves the flag unchanged.
- R4: If an event and a write-1-to-clear of the same flag fall in the same cycle, the flag stays set.
- R5: Every event, of either type, overwrites the channel's captured address (offset 0x100+n*0x10) and syndrome (offset 0x104+n*0x10).
- R6: The 8-bit counter at offset 0x108+n*0x10 increments by one on each correctable event. Non-correctable events leave it unchanged.
- R7: The counter saturates at 255 and does not wrap.
- R8: Any write to a channel's counter offset sets that counter to 0 and leaves every other channel unchanged. If a correctable event for the same channel arrives in the same cycle, the counter becomes 1.
- R9: The interrupt output is high exactly when at least one flag and its matching enable are both 1, across all channels.
- R10: Read data appears on the cycle after the address is presented. After reset, all registers and the interrupt output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | NUM_CH | Per-channel event strobe, one cycle per event |
| ev_uncorr | input | NUM_CH | Event type: 1 for non-correctable, 0 for correctable |
| ev_addr | input | NUM_CH*ADDR_W | Faulting address for each channel |
| ev_synd | input | NUM_CH*SYND_W | Syndrome for each channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid one cycle after the address |
| irq | output | 1 | Combined interrupt |

## Verification
Two pairs of operations can fall in the same cycle. A new event can meet a write-1-to-clear of the very flag it sets. A correctable event can meet a software clear of the same channel's counter. The bench drives each pair on the same clock edge from one task. It then reads the flag back and expects it still set, and reads the counter back and expects exactly 1. For each pair, the outcome the other order would give is a clear failure.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;
  // lowest bit of a channel nibble inside its control/status word
  function automatic int nib_lsb(input int ch);
    return (7 - (ch % 8)) * 4;
  endfunction

  localparam int CTRL0_OFS  = 'h000;
  localparam int CTRL1_OFS  = 'h004;
  localparam int STAT0_OFS  = 'h010;
  localparam int STAT1_OFS  = 'h014;
  localparam int GRP_BASE   = 'h100;
  localparam int GRP_STRIDE = 'h010;
  localparam int GRP_ADDR   = 'h0;
  localparam int GRP_SYND   = 'h4;
  localparam int GRP_CNT    = 'h8;
endpackage

// File: rtl/ecc_err_channel.sv
module ecc_err_channel #(
  parameter int ADDR_W = 32,
  parameter int SYND_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic              ev_uncorr,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [SYND_W-1:0] ev_synd,
  input  logic              en_we,
  input  logic              clr_we,
  input  logic [1:0]        wbits,
  input  logic              cnt_clr,
  output logic [1:0]        en,
  output logic [1:0]        flag,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [SYND_W-1:0] cap_synd,
  output logic [CNT_W-1:0]  cnt,
  output logic              irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic              corr_ev, unc_ev;
  logic [1:0]        en_q, en_d, flag_q, flag_d;
  logic [ADDR_W-1:0] addr_q;
  logic [SYND_W-1:0] synd_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_base;

  assign corr_ev = ev_valid & ~ev_uncorr;
  assign unc_ev  = ev_valid &  ev_uncorr;

  always_comb begin
    en_d      = en_we ? wbits : en_q;
    // index 1: correctable, index 0: non-correctable; a new event beats a clear
    flag_d[1] = corr_ev | (flag_q[1] & ~(clr_we & wbits[1]));
    flag_d[0] = unc_ev  | (flag_q[0] & ~(clr_we & wbits[0]));
    cnt_base  = cnt_clr ? '0 : cnt_q;
    cnt_d     = (corr_ev && cnt_base != CNT_MAX) ? cnt_base + CNT_W'(1) : cnt_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      flag_q <= '0;
      cnt_q  <= '0;
    end else begin
      en_q   <= en_d;
      flag_q <= flag_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      synd_q <= '0;
    end else if (ev_valid) begin
      addr_q <= ev_addr;
      synd_q <= ev_synd;
    end
  end

  assign en       = en_q;
  assign flag     = flag_q;
  assign cap_addr = addr_q;
  assign cap_synd = synd_q;
  assign cnt      = cnt_q;
  assign irq      = |(flag_q & en_q);

  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_uncorr) |=> flag[1]);
  // R3
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && wbits[0] && !(ev_valid && ev_uncorr)) |=> !flag[0]);
  // R5
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> (cap_addr == $past(ev_addr) && cap_synd == $past(ev_synd)));
  // R6
  unc_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_uncorr && !cnt_clr) |=> $stable(cnt));
  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !cnt_clr) |=> cnt == CNT_MAX);
endmodule

// File: rtl/ecc_err_regif.sv
module ecc_err_regif #(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 32,
  parameter int SYND_W = 8,
  parameter int CNT_W  = 8,
  parameter int REG_AW = 12,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_we,
  input  logic [REG_AW-1:0]             reg_addr,
  input  logic [DATA_W-1:0]             reg_wdata,
  output logic [DATA_W-1:0]             reg_rdata,
  output logic [NUM_CH-1:0]             en_we,
  output logic [NUM_CH-1:0]             clr_we,
  output logic [NUM_CH-1:0]             cnt_clr,
  output logic [NUM_CH-1:0][1:0]        wbits,
  input  logic [NUM_CH-1:0][1:0]        en,
  input  logic [NUM_CH-1:0][1:0]        flag,
  input  logic [NUM_CH-1:0][ADDR_W-1:0] cap_addr,
  input  logic [NUM_CH-1:0][SYND_W-1:0] cap_synd,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  cnt
);
  import ecc_err_pkg::*;

  localparam logic [REG_AW-1:0] A_CTRL0 = REG_AW'(CTRL0_OFS);
  localparam logic [REG_AW-1:0] A_CTRL1 = REG_AW'(CTRL1_OFS);
  localparam logic [REG_AW-1:0] A_STAT0 = REG_AW'(STAT0_OFS);
  localparam logic [REG_AW-1:0] A_STAT1 = REG_AW'(STAT1_OFS);

  logic [DATA_W-1:0] rd_d, rd_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_wr
    localparam logic [REG_AW-1:0] A_CT = (i < 8) ? A_CTRL0 : A_CTRL1;
    localparam logic [REG_AW-1:0] A_ST = (i < 8) ? A_STAT0 : A_STAT1;
    localparam logic [REG_AW-1:0] A_CN = REG_AW'(GRP_BASE + i*GRP_STRIDE + GRP_CNT);
    assign en_we[i]   = reg_we && (reg_addr == A_CT);
    assign clr_we[i]  = reg_we && (reg_addr == A_ST);
    assign cnt_clr[i] = reg_we && (reg_addr == A_CN);
    assign wbits[i]   = reg_wdata[nib_lsb(i)+2 +: 2];
  end

  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (reg_addr == ((i < 8) ? A_CTRL0 : A_CTRL1))
        rd_d[nib_lsb(i) +: 4] = {en[i], 2'b00};
      if (reg_addr == ((i < 8) ? A_STAT0 : A_STAT1))
        rd_d[nib_lsb(i) +: 4] = {flag[i], 2'b00};
      if (reg_addr == REG_AW'(GRP_BASE + i*GRP_STRIDE + GRP_ADDR))
        rd_d = DATA_W'(cap_addr[i]);
      if (reg_addr == REG_AW'(GRP_BASE + i*GRP_STRIDE + GRP_SYND))
        rd_d = DATA_W'(cap_synd[i]);
      if (reg_addr == REG_AW'(GRP_BASE + i*GRP_STRIDE + GRP_CNT))
        rd_d = DATA_W'(cnt[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign reg_rdata = rd_q;

  // R1
  nib_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_addr) == A_CTRL0 || $past(reg_addr) == A_STAT1)
      |-> (reg_rdata & DATA_W'(32'h3333_3333)) == '0);
endmodule

// File: rtl/ecc_err_collector.sv
module ecc_err_collector #(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 32,
  parameter int SYND_W = 8,
  parameter int CNT_W  = 8,
  parameter int REG_AW = 12,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        ev_valid,
  input  logic [NUM_CH-1:0]        ev_uncorr,
  input  logic [NUM_CH*ADDR_W-1:0] ev_addr,
  input  logic [NUM_CH*SYND_W-1:0] ev_synd,
  input  logic                     reg_we,
  input  logic [REG_AW-1:0]        reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  output logic                     irq
);
  logic [1:0]                    rst_sync;
  logic                          rst_n_int;
  logic [NUM_CH-1:0]             en_we, clr_we, cnt_clr, ch_irq;
  logic [NUM_CH-1:0][1:0]        wbits, en, flag;
  logic [NUM_CH-1:0][ADDR_W-1:0] cap_addr;
  logic [NUM_CH-1:0][SYND_W-1:0] cap_synd;
  logic [NUM_CH-1:0][CNT_W-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    ecc_err_channel #(.ADDR_W(ADDR_W), .SYND_W(SYND_W), .CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .ev_valid (ev_valid[i]),
      .ev_uncorr(ev_uncorr[i]),
      .ev_addr  (ev_addr[i*ADDR_W +: ADDR_W]),
      .ev_synd  (ev_synd[i*SYND_W +: SYND_W]),
      .en_we    (en_we[i]),
      .clr_we   (clr_we[i]),
      .wbits    (wbits[i]),
      .cnt_clr  (cnt_clr[i]),
      .en       (en[i]),
      .flag     (flag[i]),
      .cap_addr (cap_addr[i]),
      .cap_synd (cap_synd[i]),
      .cnt      (cnt[i]),
      .irq      (ch_irq[i])
    );
  end

  ecc_err_regif #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .SYND_W(SYND_W),
    .CNT_W(CNT_W), .REG_AW(REG_AW), .DATA_W(DATA_W)
  ) u_regif (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .en_we    (en_we),
    .clr_we   (clr_we),
    .cnt_clr  (cnt_clr),
    .wbits    (wbits),
    .en       (en),
    .flag     (flag),
    .cap_addr (cap_addr),
    .cap_synd (cap_synd),
    .cnt      (cnt)
  );

  assign irq = |ch_irq;

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (flag == '0) |-> !irq);
endmodule

// File: tb/sim_ecc_err_collector.sv
module sim_ecc_err_collector;
  localparam int NCH = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NCH-1:0]  ev_valid, ev_uncorr;
  logic [NCH*32-1:0] ev_addr;
  logic [NCH*8-1:0]  ev_synd;
  logic            reg_we;
  logic [11:0]     reg_addr;
  logic [31:0]     reg_wdata, reg_rdata;
  logic            irq;

  int n_chk = 0;
  int n_fail = 0;

  ecc_err_collector u0 (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_uncorr(ev_uncorr),
    .ev_addr(ev_addr), .ev_synd(ev_synd), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic event_pulse(input int ch, input logic unc, input logic [31:0] a, input logic [7:0] s);
    @(negedge clk);
    ev_valid[ch] = 1'b1; ev_uncorr[ch] = unc;
    ev_addr[ch*32 +: 32] = a; ev_synd[ch*8 +: 8] = s;
    @(negedge clk);
    ev_valid[ch] = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R10 ctrl0 reset", 12'h000, 32'h0);
    rd_chk("R10 stat1 reset", 12'h014, 32'h0);
    rd_chk("R10 cnt3 reset", 12'h138, 32'h0);
    check("R10 irq reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_map;
    wr(12'h000, 32'hFFFF_FFFF);
    rd_chk("R1 ctrl0 nibble mask", 12'h000, 32'hCCCC_CCCC);
    wr(12'h004, 32'h8000_0007);
    rd_chk("R1 ctrl1 ch8 top ch15 bottom", 12'h004, 32'h8000_0004);
    wr(12'h000, 32'h0);
    wr(12'h004, 32'h0);
    rd_chk("R1 ctrl0 cleared", 12'h000, 32'h0);
  endtask

  task automatic t_flags;
    event_pulse(0, 1'b0, 32'h0000_1000, 8'h11);
    rd_chk("R2 ch0 correctable flag", 12'h010, 32'h8000_0000);
    event_pulse(15, 1'b1, 32'h0000_2000, 8'h22);
    event_pulse(9, 1'b0, 32'h0000_3000, 8'h33);
    rd_chk("R2 stat1 ch9 corr ch15 uncorr", 12'h014, 32'h0800_0004);
  endtask

  task automatic t_w1c;
    wr(12'h014, 32'h0);
    rd_chk("R3 write 0 keeps flags", 12'h014, 32'h0800_0004);
    wr(12'h014, 32'h0000_0004);
    rd_chk("R3 clear ch15 only", 12'h014, 32'h0800_0000);
    wr(12'h010, 32'h8000_0000);
    rd_chk("R3 clear ch0", 12'h010, 32'h0);
  endtask

  task automatic t_capture;
    event_pulse(5, 1'b0, 32'hDEAD_0040, 8'h5A);
    event_pulse(5, 1'b1, 32'hBEEF_0080, 8'hC3);
    rd_chk("R5 addr of last event", 12'h150, 32'hBEEF_0080);
    rd_chk("R5 syndrome of last event", 12'h154, 32'h0000_00C3);
    rd_chk("R6 uncorrectable not counted", 12'h158, 32'h1);
    wr(12'h010, 32'h0000_0C00);
  endtask

  task automatic t_race;
    event_pulse(2, 1'b0, 32'h10, 8'h1);
    @(negedge clk);
    ev_valid[2] = 1'b1; ev_uncorr[2] = 1'b0;
    reg_we = 1'b1; reg_addr = 12'h010; reg_wdata = 32'h0080_0000;
    @(negedge clk);
    ev_valid[2] = 1'b0; reg_we = 1'b0;
    rd_chk("R4 event beats clear", 12'h010, 32'h0080_0000);
    wr(12'h010, 32'h0080_0000);
    rd_chk("R4 later clear works", 12'h010, 32'h0);
  endtask

  task automatic t_irq;
    check("R9 flag without enable", {31'b0, irq}, 32'h0);
    wr(12'h004, 32'h0800_0000);
    check("R9 enabled ch9 flag", {31'b0, irq}, 32'h1);
    wr(12'h004, 32'h0400_0000);
    check("R9 mismatched enable", {31'b0, irq}, 32'h0);
    wr(12'h004, 32'h0800_0000);
    wr(12'h014, 32'h0800_0000);
    check("R9 cleared flag drops irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_count;
    @(negedge clk);
    ev_valid[3] = 1'b1; ev_uncorr[3] = 1'b0;
    repeat (280) @(negedge clk);
    ev_valid[3] = 1'b0;
    rd_chk("R7 saturate at 255", 12'h138, 32'h0000_00FF);
    event_pulse(4, 1'b0, 32'h4, 8'h4);
    wr(12'h138, 32'h0);
    rd_chk("R8 ch3 counter cleared", 12'h138, 32'h0);
    rd_chk("R8 ch4 counter untouched", 12'h148, 32'h1);
    event_pulse(4, 1'b0, 32'h4, 8'h4);
    rd_chk("R6 ch4 counts to 2", 12'h148, 32'h2);
    @(negedge clk);
    ev_valid[4] = 1'b1; ev_uncorr[4] = 1'b0;
    reg_we = 1'b1; reg_addr = 12'h148; reg_wdata = 32'h0;
    @(negedge clk);
    ev_valid[4] = 1'b0; reg_we = 1'b0;
    rd_chk("R8 clear with event gives 1", 12'h148, 32'h1);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    ev_valid = '0; ev_uncorr = '0; ev_addr = '0; ev_synd = '0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_map();
    t_flags();
    t_w1c();
    t_capture();
    t_race();
    t_irq();
    t_count();
    summary();
  end
endmodule